// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block watches over twelve power switches wired as six high-side/low-side pairs. It takes the requested on/off state of every switch, plus three protection-enable bits, from a control word. It also takes digital fault flags from analog comparators. It drives the gated switch enables and keeps a latched status word for diagnostics. Per-switch overcurrent and open-load flags must stay high for a programmable number of clock cycles before they count. A qualified fault turns off only the switch concerned. Supply and thermal lockouts turn off every switch for as long as they last.

Switch index `i` in the enable, flag and status vectors follows one fixed order. Index 0 is the low side of pair 1 and index 1 is its high side. The same pattern repeats up to index 11, the high side of pair 6. A switch turned off by its own fault stays off until software acknowledges it. Supply and thermal lockouts hold nothing: the control word is kept, so the outputs come back by themselves when the condition ends.

Top module: `hb_fault_supervisor`

## Requirements
- R1: After reset all switch enables are low, the status word is zero and the stored control word is zero.
- R2: A control write stores the word. Bit `i+1` requests switch `i` (bit 1 = low side of pair 1, bit 2 = high side of pair 1, … bit 12 = high side of pair 6). From the next cycle, with no fault, `sw_en[i]` equals that bit.
- R3: An overcurrent flag must stay high for OC_CYC consecutive cycles to qualify. The switch turns off on the cycle after that, i.e. after OC_CYC+1 rising edges. A shorter pulse restarts the filter and has no effect.
- R4: An open-load flag qualifies the same way after OL_CYC consecutive cycles. The switch turns off after OL_CYC+1 edges.
- R5: Control bit 13 enables overcurrent shutdown and bit 14 enables open-load shutdown. When the matching bit is low, a qualified fault turns nothing off but is still latched in the status word.
- R6: A qualified per-switch fault turns off only that switch; all other enables are unchanged.
- R7: Status bit `i+1` latches a qualified fault of switch `i`. Bit 13 latches any qualified overcurrent and bit 14 any qualified open-load. Status bits stay set until a clear.
- R8: Supply undervoltage forces every enable low in the same cycle for as long as it is present, and latches status bit 15. The control word is kept, so the enables come back once the flag drops.
- R9: Supply overvoltage latches status bit 15 in every case. It forces every enable low only while control bit 15 is high.
- R10: Thermal shutdown forces every enable low while present. Thermal prewarning gates nothing. Both latch status bit 0.
- R11: A control write with bit 0 high clears the status word and all per-switch trips. A condition that sets a status bit or a trip in that same cycle wins over the clear.
- R12: A tripped switch stays off after its fault flag drops. It is released by a clear (R11) or by a control write whose request bit for that switch is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | One-cycle strobe: ctrl_word is a new control word |
| ctrl_word | input | 16 | Control word (bit 0 clear, bits 12:1 requests, 13/14/15 enables) |
| oc_flag | input | 12 | Raw overcurrent comparator flag per switch |
| ol_flag | input | 12 | Raw open-load comparator flag per switch |
| uv_flag | input | 1 | Supply undervoltage |
| ov_flag | input | 1 | Supply overvoltage |
| tsd_flag | input | 1 | Thermal shutdown |
| tpw_flag | input | 1 | Thermal prewarning |
| sw_en | output | 12 | Gated switch enables |
| status | output | 16 | Latched diagnostic word |

## Verification
Two events can land on the same clock edge. The first is a software status clear. The second is a filter counter reaching its limit, which both sets a status bit and trips a switch. The bench holds an overcurrent flag for exactly OC_CYC cycles and issues the clearing write on the edge where that fault qualifies. It then expects the switch off and its status bits set, because setting must beat clearing. Random runs also produce such overlaps, along with writes that collide with lockouts. Every cycle is compared against a reference model built from the requirements.

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor #(
  parameter int PAIRS  = 6,
  parameter int OC_CYC = 16,
  parameter int OL_CYC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_wr,
  input  logic [2*PAIRS+3:0]     ctrl_word,
  input  logic [2*PAIRS-1:0]     oc_flag,
  input  logic [2*PAIRS-1:0]     ol_flag,
  input  logic                   uv_flag,
  input  logic                   ov_flag,
  input  logic                   tsd_flag,
  input  logic                   tpw_flag,
  output logic [2*PAIRS-1:0]     sw_en,
  output logic [2*PAIRS+3:0]     status
);
  localparam int NSW   = 2 * PAIRS;
  localparam int W     = NSW + 4;
  localparam int OC_EN = NSW + 1;
  localparam int OL_EN = NSW + 2;
  localparam int OV_EN = NSW + 3;
  localparam int OCW   = $clog2(OC_CYC + 1);
  localparam int OLW   = $clog2(OL_CYC + 1);

  logic [W-1:1]   ctrl_q;
  logic [W-1:0]   status_q;
  logic [NSW-1:0] trip_q;
  logic [NSW-1:0] oc_q, ol_q;

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    logic [OCW-1:0] oc_cnt;
    logic [OLW-1:0] ol_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            oc_cnt <= '0;
      else if (!oc_flag[i])                  oc_cnt <= '0;
      else if (oc_cnt != OCW'(OC_CYC))       oc_cnt <= oc_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ol_cnt <= '0;
      else if (!ol_flag[i])                  ol_cnt <= '0;
      else if (ol_cnt != OLW'(OL_CYC))       ol_cnt <= ol_cnt + 1'b1;
    end

    assign oc_q[i] = (oc_cnt == OCW'(OC_CYC));
    assign ol_q[i] = (ol_cnt == OLW'(OL_CYC));
  end

  wire            clr  = ctrl_wr & ctrl_word[0];
  wire [NSW-1:0]  req  = ctrl_q[NSW:1];
  wire [NSW-1:0]  rel  = {NSW{clr}} | ({NSW{ctrl_wr}} & ~ctrl_word[NSW:1]);
  wire [NSW-1:0]  hit  = (oc_q & {NSW{ctrl_q[OC_EN]}}) | (ol_q & {NSW{ctrl_q[OL_EN]}});
  wire            lock = uv_flag | (ov_flag & ctrl_q[OV_EN]) | tsd_flag;
  wire [W-1:0]    setv = {uv_flag | ov_flag, |ol_q, |oc_q, oc_q | ol_q, tpw_flag | tsd_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      trip_q   <= '0;
      status_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_word[W-1:1];
      trip_q   <= (trip_q & ~rel) | hit;
      status_q <= (clr ? '0 : status_q) | setv;
    end
  end

  assign sw_en  = req & ~trip_q & {NSW{~lock}};
  assign status = status_q;
endmodule

// File: rtl/hb_fault_supervisor_chk.sv
module hb_fault_supervisor_chk #(
  parameter int NSW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_wr,
  input logic           clr_wr,
  input logic           ov_en,
  input logic           uv_flag,
  input logic           ov_flag,
  input logic           tsd_flag,
  input logic           tpw_flag,
  input logic [NSW-1:0] sw_en,
  input logic [NSW+3:0] status,
  input logic [NSW-1:0] trip_q
);
  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> sw_en == '0);

  p_ov_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && ov_en) |-> sw_en == '0);

  p_tsd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |-> sw_en == '0);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status & $past(status)) == $past(status)));

  p_trip_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ((trip_q & $past(trip_q)) == $past(trip_q)));

  p_trip_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip_q & ~$past(trip_q)) != '0) |-> (status[NSW+2:NSW+1] != 2'b00));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !uv_flag && !ov_flag && !tsd_flag && !tpw_flag)
      |=> (status[0] == 1'b0 && status[NSW+3] == 1'b0));
endmodule

bind hb_fault_supervisor hb_fault_supervisor_chk #(.NSW(NSW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_wr  (ctrl_wr),
  .clr_wr   (ctrl_wr & ctrl_word[0]),
  .ov_en    (ctrl_q[OV_EN]),
  .uv_flag  (uv_flag),
  .ov_flag  (ov_flag),
  .tsd_flag (tsd_flag),
  .tpw_flag (tpw_flag),
  .sw_en    (sw_en),
  .status   (status),
  .trip_q   (trip_q)
);

// File: tb/sim_hb_fault_supervisor.sv
`timescale 1ns/1ps
module sim_hb_fault_supervisor;
  localparam int OC_CYC = 16;
  localparam int OL_CYC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [11:0] oc_flag = '0, ol_flag = '0;
  logic        uv = 1'b0, ov = 1'b0, tsd = 1'b0, tpw = 1'b0;
  logic [11:0] sw_en;
  logic [15:0] status;

  int total = 0, bad = 0;
  bit done = 0;

  int          m_oc [12];
  int          m_ol [12];
  logic [11:0] m_trip = '0;
  logic [15:0] m_stat = '0;
  logic [15:1] m_ctrl = '0;

  always #2.5 clk = ~clk;

  hb_fault_supervisor #(.PAIRS(6), .OC_CYC(OC_CYC), .OL_CYC(OL_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
    .oc_flag(oc_flag), .ol_flag(ol_flag), .uv_flag(uv), .ov_flag(ov),
    .tsd_flag(tsd), .tpw_flag(tpw), .sw_en(sw_en), .status(status));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] exp_en();
    logic lock;
    lock = uv | (ov & m_ctrl[15]) | tsd;
    return m_ctrl[12:1] & ~m_trip & {12{~lock}};
  endfunction

  task automatic step();
    logic [11:0] qoc, qol, rel, hit;
    logic        clr;
    logic [15:0] setv;
    for (int i = 0; i < 12; i++) begin
      qoc[i] = (m_oc[i] == OC_CYC);
      qol[i] = (m_ol[i] == OL_CYC);
    end
    clr  = ctrl_wr & ctrl_word[0];
    rel  = {12{clr}} | ({12{ctrl_wr}} & ~ctrl_word[12:1]);
    hit  = (qoc & {12{m_ctrl[13]}}) | (qol & {12{m_ctrl[14]}});
    setv = {uv | ov, |qol, |qoc, qoc | qol, tpw | tsd};
    m_trip = (m_trip & ~rel) | hit;
    m_stat = (clr ? 16'h0 : m_stat) | setv;
    if (ctrl_wr) m_ctrl = ctrl_word[15:1];
    for (int i = 0; i < 12; i++) begin
      m_oc[i] = oc_flag[i] ? ((m_oc[i] == OC_CYC) ? OC_CYC : m_oc[i] + 1) : 0;
      m_ol[i] = ol_flag[i] ? ((m_ol[i] == OL_CYC) ? OL_CYC : m_ol[i] + 1) : 0;
    end
    @(posedge clk); #1;
    chk("R2/R6 model sw_en", {20'h0, sw_en}, {20'h0, exp_en()});
    chk("R7 model status", {16'h0, status}, {16'h0, m_stat});
  endtask

  task automatic wr(logic [15:0] w);
    ctrl_wr = 1'b1; ctrl_word = w;
    step();
    ctrl_wr = 1'b0;
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) begin m_oc[i] = 0; m_ol[i] = 0; end
    void'($urandom(32'd7019));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset sw_en", {20'h0, sw_en}, 32'h0);
    chk("R1 reset status", {16'h0, status}, 32'h0);
    rst_n = 1'b1;

    // R2 ordering of request bits
    wr(16'h0002); chk("R2 LS1 only", {20'h0, sw_en}, 32'h001);
    wr(16'h1000); chk("R2 HS6 only", {20'h0, sw_en}, 32'h800);
    wr(16'hFFFE); chk("R2 all on", {20'h0, sw_en}, 32'hFFF);

    // R3 / R6 / R7: overcurrent on switch 3 (HS2)
    oc_flag[3] = 1'b1;
    steps(OC_CYC);
    chk("R3 still on before filter ends", {20'h0, sw_en}, 32'hFFF);
    step();
    chk("R6 only HS2 off", {20'h0, sw_en}, 32'hFF7);
    chk("R7 OC status bits", {16'h0, status}, 32'h2010);
    oc_flag[3] = 1'b0;
    steps(3);
    chk("R12 stays off after flag drop", {20'h0, sw_en}, 32'hFF7);

    // R3 glitch filtering on switch 5
    oc_flag[5] = 1'b1; steps(OC_CYC - 1);
    oc_flag[5] = 1'b0; step();
    oc_flag[5] = 1'b1; steps(OC_CYC - 1);
    chk("R3 short pulses ignored", {20'h0, sw_en}, 32'hFF7);
    oc_flag[5] = 1'b0; step();

    // R12 release by writing the switch low, then on again
    wr(16'hFFEE); chk("R12 request low", {20'h0, sw_en}, 32'hFF7);
    wr(16'hFFFE); chk("R12 released", {20'h0, sw_en}, 32'hFFF);
    chk("R7 status kept without clear", {16'h0, status}, 32'h2010);
    wr(16'hFFFF); chk("R11 clear", {16'h0, status}, 32'h0);

    // R4 open load on switch 0
    ol_flag[0] = 1'b1;
    steps(OL_CYC);
    chk("R4 still on before filter ends", {20'h0, sw_en}, 32'hFFF);
    step();
    chk("R4 LS1 off", {20'h0, sw_en}, 32'hFFE);
    chk("R4 OL status bits", {16'h0, status}, 32'h4002);
    ol_flag[0] = 1'b0; step();

    // R5 protection disabled
    wr(16'h9FFF);
    oc_flag[7] = 1'b1; steps(OC_CYC + 3);
    chk("R5 no shutdown when disabled", {20'h0, sw_en}, 32'hFFF);
    chk("R5 diagnosis still latched", {16'h0, status}, 32'h2100);
    oc_flag[7] = 1'b0; step();
    wr(16'hFFFF);

    // R8 undervoltage
    uv = 1'b1; #1;
    chk("R8 all off same cycle", {20'h0, sw_en}, 32'h0);
    step();
    chk("R8 bit 15 latched", {16'h0, status}, 32'h8000);
    uv = 1'b0; #1;
    chk("R8 resume without rewrite", {20'h0, sw_en}, 32'hFFF);
    step();

    // R9 overvoltage with lockout disabled, then enabled
    wr(16'h7FFF);
    ov = 1'b1; step();
    chk("R9 no lockout when disabled", {20'h0, sw_en}, 32'hFFF);
    chk("R9 reported", {16'h0, status}, 32'h8000);
    ov = 1'b0; step();
    wr(16'hFFFF);
    ov = 1'b1; #1;
    chk("R9 lockout when enabled", {20'h0, sw_en}, 32'h0);
    step(); ov = 1'b0; step();
    wr(16'hFFFF);

    // R10 thermal
    tpw = 1'b1; step();
    chk("R10 prewarn keeps outputs", {20'h0, sw_en}, 32'hFFF);
    chk("R10 prewarn bit 0", {16'h0, status}, 32'h0001);
    tpw = 1'b0; wr(16'hFFFF);
    tsd = 1'b1; #1;
    chk("R10 shutdown all off", {20'h0, sw_en}, 32'h0);
    step();
    chk("R10 shutdown bit 0", {16'h0, status}, 32'h0001);
    tsd = 1'b0; step();
    chk("R10 resume", {20'h0, sw_en}, 32'hFFF);
    wr(16'hFFFF);

    // R11 clear colliding with a qualifying fault
    oc_flag[10] = 1'b1; steps(OC_CYC);
    wr(16'hFFFF);
    chk("R11 set beats clear status", {16'h0, status}, 32'h2800);
    chk("R11 trip beats clear", {20'h0, sw_en}, 32'hBFF);
    oc_flag[10] = 1'b0; step();
    wr(16'hFFFF);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 32 == 0) oc_flag[$urandom % 12] ^= 1'b1;
      if ($urandom % 96 == 0) ol_flag[$urandom % 12] ^= 1'b1;
      if ($urandom % 300 == 0) uv  = ~uv;
      if ($urandom % 300 == 0) ov  = ~ov;
      if ($urandom % 300 == 0) tsd = ~tsd;
      if ($urandom % 300 == 0) tpw = ~tpw;
      if ($urandom % 60 == 0) begin
        ctrl_wr = 1'b1;
        ctrl_word = {16'($urandom) & 16'hFFFE} | {15'h0, ($urandom % 4 == 0)};
      end
      step();
      ctrl_wr = 1'b0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule